// File: doc/BRIEF.md
# Encoded-Ratio Clock Divider Bank

This block turns one fast input clock (the oscillator-rate clock) into four slower clocks. Three of them come from independent divider channels: a processor channel, a link channel and a serial-reference channel. Each channel has a 4-bit ratio code. A fourth output runs at half the link channel's frequency. The ratio code has two fields: a base field that picks one of four base ratios, and a scale field that multiplies the base by a power of two. Each channel has its own set of base ratios, so the same code gives different ratios on different channels.

Every output has an exact 50% duty cycle, odd ratios included. For odd ratios the high phase ends on a falling edge of the input clock, so it lasts half an input cycle longer than the integer part. Every output rises on a rising edge of the input clock. A channel reads its code only when the current output period ends. Changing the code mid-period therefore never shortens or stretches the period in progress. The block is intended to sit behind configuration registers that hold the three codes. It has no register access of its own.

Top module: `clkdiv_bank`

## Requirements
- R1: While rst_ni is low all four outputs are low. The first output period of every channel starts on the first rising clock edge that samples rst_ni high.
- R2: A ratio code splits into two fields. Bits 1:0 pick the channel's base ratio, listed below in code order 00, 01, 10, 11. Bits 3:2 give k, and the divide ratio is the base times 2 to the power k (k = 0 to 3).
- R3: Base ratios of the processor channel (cpu_code_i): 2, 3, 5, 15. Code 1111 divides by 120.
- R4: Base ratios of the link channel (htt_code_i): 4, 3, 5, 15. Code 0000 divides by 4 and code 1100 divides by 32.
- R5: Base ratios of the serial-reference channel (src_code_i): 2, 3, 5, 7. Code 1111 divides by 56.
- R6: For an even ratio N, an output period lasts N input cycles. The output is high for the first N/2 cycles, starting at a rising input edge.
- R7: For an odd ratio N, an output period lasts N input cycles. The output is high for the first N input half-cycles: it rises on a rising input edge and falls on a falling input edge.
- R8: A channel samples its code only on the rising input edge that starts a new output period. The period in progress always runs to its full length at the old ratio.
- R9: pci_clk_o toggles exactly at the start of each link-channel output period. It is therefore high for one whole link period and low for the next, and its rising edges fall on every other rising edge of htt_clk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_code_i | input | 4 | Ratio code of the processor channel |
| htt_code_i | input | 4 | Ratio code of the link channel |
| src_code_i | input | 4 | Ratio code of the serial-reference channel |
| cpu_clk_o | output | 1 | Processor channel divided clock |
| htt_clk_o | output | 1 | Link channel divided clock |
| pci_clk_o | output | 1 | Half-rate copy of the link channel clock |
| src_clk_o | output | 1 | Serial-reference channel divided clock |

## Verification
The reference model predicts all four outputs for every input half-cycle, so it checks period length and duty together on both clock phases. A sweep runs all sixteen codes on all three channels. The sweep separates the three base sets, the four multipliers, and even from odd ratios, because an odd ratio is only right if the high phase ends on a falling edge. A directed run switches from the longest processor ratio to a short one early in a period; it shows that the running period still completes at its old length. Random code changes at arbitrary times, plus a reset applied in the middle of a run, exercise reloads at period boundaries and the half-rate output's toggle phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CODE_W  = 4;
    localparam int BASE_W  = 2;
    localparam int RATIO_W = 7;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [CODE_W-1:0]  code_t;

    typedef enum logic [1:0] {
        CH_CPU = 2'd0,
        CH_HTT = 2'd1,
        CH_SRC = 2'd2
    } chan_e;

    // Base ratio chosen by the low code field, per channel family.
    function automatic ratio_t base_ratio(chan_e ch, logic [BASE_W-1:0] sel);
        ratio_t r;
        case (sel)
            2'd0:    r = (ch == CH_HTT) ? ratio_t'(4) : ratio_t'(2);
            2'd1:    r = ratio_t'(3);
            2'd2:    r = ratio_t'(5);
            default: r = (ch == CH_SRC) ? ratio_t'(7) : ratio_t'(15);
        endcase
        return r;
    endfunction

    // Full ratio: base scaled by a power of two from the upper field.
    function automatic ratio_t decode_ratio(chan_e ch, code_t code);
        return ratio_t'(base_ratio(ch, code[BASE_W-1:0]) << code[CODE_W-1:BASE_W]);
    endfunction

endpackage

// File: rtl/clkdiv_half.sv
module clkdiv_half (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic clk_o
);

    logic half_d, half_q;

    always_comb begin
        half_d = half_q;
        if (start_i) begin
            half_d = ~half_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            half_q <= 1'b0;
        end else begin
            half_q <= half_d;
        end
    end

    assign clk_o = half_q;

    AST_HALF_HOLDS_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(half_q)); // R9
    AST_HALF_FLIPS_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (half_q != $past(half_q))); // R9

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
    import clkdiv_pkg::*;
#(
    parameter chan_e KIND = CH_CPU,
    localparam int NOUT = (KIND == CH_HTT) ? 2 : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [CODE_W-1:0] code_i,
    output logic [NOUT-1:0] clk_o
);

    typedef struct packed {
        ratio_t cnt;
        ratio_t ratio;
        logic   hi;
        logic   odd;
    } chan_st_t;

    localparam ratio_t ONE = ratio_t'(1);

    chan_st_t st_d, st_q;
    logic     neg_q;
    logic     wrap;
    ratio_t   next_ratio;

    always_comb begin
        next_ratio = decode_ratio(KIND, code_i);
        wrap       = (st_q.cnt == (st_q.ratio - ONE));
        st_d       = st_q;
        if (wrap) begin
            st_d.cnt   = '0;
            st_d.ratio = next_ratio;
            st_d.odd   = next_ratio[0];
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
        st_d.hi = (st_d.cnt < (st_d.ratio >> 1));
    end

    // Reset state: ratio of one so the first live edge starts a period.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, ratio: ONE, hi: 1'b0, odd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Falling-edge copy stretches odd ratios by half an input cycle.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= st_q.hi;
        end
    end

    assign clk_o[0] = st_q.hi | (st_q.odd & neg_q);

    generate
        if (KIND == CH_HTT) begin : g_half
            clkdiv_half u_half (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .start_i (wrap),
                .clk_o   (clk_o[1])
            );
        end
    endgenerate

    AST_RATIO_HELD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(st_q.ratio)); // R8
    AST_RISE_AT_PERIOD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> st_q.hi); // R6
    AST_LOW_IN_LAST_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.cnt == (st_q.ratio - ONE)) && (st_q.ratio > ONE)) |-> !st_q.hi); // R7
    AST_RATIO_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> (st_q.ratio >= ratio_t'(2))); // R2

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] cpu_code_i,
    input  logic [3:0] htt_code_i,
    input  logic [3:0] src_code_i,
    output logic       cpu_clk_o,
    output logic       htt_clk_o,
    output logic       pci_clk_o,
    output logic       src_clk_o
);

    logic [0:0] cpu_out;
    logic [1:0] htt_out;
    logic [0:0] src_out;

    clkdiv_channel #(.KIND(CH_CPU)) u_cpu (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (cpu_code_i),
        .clk_o  (cpu_out)
    );

    clkdiv_channel #(.KIND(CH_HTT)) u_htt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (htt_code_i),
        .clk_o  (htt_out)
    );

    clkdiv_channel #(.KIND(CH_SRC)) u_src (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (src_code_i),
        .clk_o  (src_out)
    );

    assign cpu_clk_o = cpu_out[0];
    assign htt_clk_o = htt_out[0];
    assign pci_clk_o = htt_out[1];
    assign src_clk_o = src_out[0];

endmodule

// File: tb/clkdiv_bank_tb_top.sv
`timescale 1ns/1ps
module clkdiv_bank_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    logic [3:0] code [3];
    logic       cpu_o, htt_o, pci_o, src_o;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    clkdiv_bank dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cpu_code_i (code[0]),
        .htt_code_i (code[1]),
        .src_code_i (code[2]),
        .cpu_clk_o  (cpu_o),
        .htt_clk_o  (htt_o),
        .pci_clk_o  (pci_o),
        .src_clk_o  (src_o)
    );

    // Ratio from requirements R2..R5: channel 0 cpu, 1 link, 2 serial-ref.
    function automatic int dec(int ch, int c);
        int b [3][4] = '{'{2, 3, 5, 15}, '{4, 3, 5, 15}, '{2, 3, 5, 7}};
        return b[ch][c % 4] << (c / 4);
    endfunction

    function automatic logic pick(int sel);
        case (sel)
            0:       return cpu_o;
            1:       return htt_o;
            2:       return src_o;
            default: return pci_o;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, compared every half-cycle.
    int  cyc [3];
    int  rat [3];
    int  lat_code [3];
    bit  lat_rst = 0;
    bit  started = 0;
    bit  pci_e = 0;

    task automatic zero_check();
        for (int s = 0; s < 4; s++) begin
            chk(pick(s) == 1'b0, "R1 output low in reset", int'(pick(s)), 0);
        end
    endtask

    task automatic compare(int h);
        string ctag [3] = '{"R3", "R4", "R5"};
        for (int ch = 0; ch < 3; ch++) begin
            bit e = ((2 * cyc[ch] + h) < rat[ch]);
            string t = $sformatf("%s/%s ch%0d ratio %0d half %0d", ctag[ch],
                                 (rat[ch] % 2) ? "R7" : "R6", ch, rat[ch], h);
            chk(pick(ch) == e, t, int'(pick(ch)), int'(e));
        end
        chk(pci_o == pci_e, "R9 half-rate output", int'(pci_o), int'(pci_e));
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            cyc[i] = 0; rat[i] = 2; lat_code[i] = 0;
        end
        forever begin
            @(posedge clk); #1;
            if (!rst_n || !lat_rst) begin
                started = 0; pci_e = 0;
                zero_check();
            end else begin
                for (int ch = 0; ch < 3; ch++) begin
                    if (!started || cyc[ch] == rat[ch] - 1) begin
                        rat[ch] = dec(ch, lat_code[ch]);
                        cyc[ch] = 0;
                        if (ch == 1) pci_e = !pci_e;
                    end else begin
                        cyc[ch]++;
                    end
                end
                started = 1;
                compare(0);
            end
            @(negedge clk); #1;
            if (!rst_n || !lat_rst) zero_check();
            else compare(1);
            lat_rst = rst_n;
            for (int i = 0; i < 3; i++) lat_code[i] = int'(code[i]);
        end
    end

    task automatic set_codes(int a, int b, int c);
        @(posedge clk); #0.5;
        code[0] = 4'(a); code[1] = 4'(b); code[2] = 4'(c);
    endtask

    task automatic wait_rise(int sel);
        logic prev, cur;
        @(posedge clk); #1; prev = pick(sel);
        forever begin
            @(posedge clk); #1; cur = pick(sel);
            if (cur && !prev) break;
            prev = cur;
        end
    endtask

    // Cycles from one rise to the next; optional code change after chg_at cycles.
    task automatic count_period(int sel, int chg_at, int chg_val, output int n);
        logic prev, cur;
        n = 0; prev = 1'b1;
        forever begin
            @(posedge clk); #1; n++;
            if (n == chg_at) code[0] = 4'(chg_val);
            cur = pick(sel);
            if (cur && !prev) break;
            prev = cur;
        end
    endtask

    task automatic meas(int sel, int exp, string tag);
        int n;
        wait_rise(sel);
        count_period(sel, -1, 0, n);
        chk(n == exp, tag, n, exp);
    endtask

    initial begin
        int n;
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) code[i] = 4'd0;
        repeat (4) @(posedge clk);
        #0.5 rst_n = 1'b1;
        repeat (40) @(posedge clk);

        // Full code sweep on all channels: R2 with each base set.
        for (int k = 0; k < 16; k++) begin
            set_codes(k, k, k);
            repeat (250) @(posedge clk);
            meas(0, dec(0, k), $sformatf("R2/R3 cpu code %0d period", k));
            meas(1, dec(1, k), $sformatf("R2/R4 link code %0d period", k));
            meas(2, dec(2, k), $sformatf("R2/R5 serial code %0d period", k));
            meas(3, 2 * dec(1, k), $sformatf("R9 half-rate period code %0d", k));
        end

        // R8: code change early in a long period does not cut it short.
        set_codes(15, 0, 0);
        repeat (250) @(posedge clk);
        wait_rise(0);
        count_period(0, 10, 1, n);
        chk(n == 120, "R8 running period keeps old ratio", n, 120);
        count_period(0, -1, 0, n);
        chk(n == 3, "R8 next period uses new ratio", n, 3);

        // Random codes changed at arbitrary times.
        repeat (300) begin
            set_codes(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
            repeat (1 + ($urandom % 60)) @(posedge clk);
        end

        // Reset in the middle of a run.
        @(posedge clk); #0.5 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        repeat (200) @(posedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule